// File: doc/BRIEF.md
# Timer/Event Counter with Overflow Wake-up

The block is an up-counter that takes its count source from one of two places. In timer mode it advances on every system clock. In event mode it advances on a chosen transition of an external input, which is first passed through a synchronizer. When the counter passes all-ones it reloads from a preload register rather than wrapping to zero. The same overflow sets an interrupt request flag and may send a one-cycle wake-up pulse to the power controller.

The host has four kinds of access:
- It writes a control byte that holds the run, source, edge and interrupt-enable bits.
- It writes the preload value.
- It reads the live count.
- It sets or clears the request flag.

In any cycle where the host reads the count or writes the preload, the count step for that cycle is dropped. Software reading the count must allow for that lost step.

A wake-up is produced on every overflow, whatever the interrupt-enable setting, as long as the request flag was clear beforehand. Software that wants no wake-up from this source during power-down sets the flag before it halts.

Top module: `tmr_event_counter`

## Requirements
- R1: After reset, the count is 0, the request flag is 0, `irq` is 0, `wake` is 0 and the counter is stopped.
- R2: Control byte bits: bit 4 is run, bit 0 is source (0 = system clock, 1 = external event), bit 1 is edge select (0 = rising, 1 = falling), bit 2 is interrupt enable. The control write takes effect on the clock edge that ends the write cycle. With run = 1 and source = 0, the count rises by one on each following clock. With run = 0, the count holds.
- R3: With source = 1, the count rises by one for each selected transition of `evt_in`. The step happens on the third clock edge after the transition: two synchronizer stages, then the edge register.
- R4: A count step taken from all-ones loads the preload value into the counter instead of zero. This is the overflow.
- R5: Overflow sets the request flag. `irq` is high exactly when the flag and the interrupt-enable bit are both set.
- R6: `wake` is a pulse one cycle long, in the cycle after an overflow. It occurs whatever the interrupt-enable bit is, and only if the request flag was clear in the overflow cycle.
- R7: In a cycle with `cnt_re` or `preload_we` high, the counter takes no count step, and that step is lost.
- R8: A preload write while stopped also loads the counter. A preload write while running changes only the preload, which the counter uses at the next overflow.
- R9: A `flag_we` write sets the flag to `flag_wdata`. A clear write in the same cycle as an overflow leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte value |
| preload_we | input | 1 | Preload write strobe |
| preload_wdata | input | CNT_W | Preload value |
| cnt_re | input | 1 | Count read strobe (inhibits counting) |
| cnt_rdata | output | CNT_W | Live count value |
| flag_we | input | 1 | Request flag write strobe |
| flag_wdata | input | 1 | Request flag value to write |
| evt_in | input | 1 | External event input (asynchronous) |
| irq | output | 1 | Interrupt request (flag and enable) |
| irq_flag | output | 1 | Request flag state |
| wake | output | 1 | Wake-up pulse on overflow |

## Verification
On every cycle, the assertions check the following:
- The count holds while the counter is stopped or a host access inhibits it.
- An overflow lands on the preload value and sets the flag.
- Every wake pulse traces back to an overflow that found the flag clear.
- Neither the wake pulse nor a detected edge lasts two cycles.

The step-by-step arithmetic can only be shown by the bench scenarios. These cover:
- the exact count after a given number of clocks for every preload value;
- the latency and edge selection in event mode;
- the single lost step around a read or preload write;
- the deferred preload taking effect at the next overflow;
- a clear that collides with an overflow.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
    localparam int CTRL_W    = 8;
    localparam int SRC_BIT   = 0;
    localparam int EDGE_BIT  = 1;
    localparam int IE_BIT    = 2;
    localparam int RUN_BIT   = 4;

    typedef enum logic {SRC_CLK = 1'b0, SRC_EVT = 1'b1} src_e;
    typedef enum logic {EDGE_RISE = 1'b0, EDGE_FALL = 1'b1} edge_e;

    typedef struct packed {
        logic  run;
        src_e  src;
        edge_e edge_sel;
        logic  ie;
    } tmr_ctrl_t;

    function automatic tmr_ctrl_t make_ctrl(input logic run_b, input logic src_b,
                                            input logic edge_b, input logic ie_b);
        tmr_ctrl_t c;
        c.run      = run_b;
        c.src      = src_e'(src_b);
        c.edge_sel = edge_e'(edge_b);
        c.ie       = ie_b;
        return c;
    endfunction

    function automatic logic pick_edge(input edge_e sel, input logic cur, input logic prev);
        return (sel == EDGE_RISE) ? (cur & ~prev) : (~cur & prev);
    endfunction
endpackage

// File: rtl/tmr_evt_detect.sv
`timescale 1ns/1ps
module tmr_evt_detect
    import tmr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  evt_in,
    input  edge_e edge_sel,
    output logic  evt_pulse
);
    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[SH_W-2:0], evt_in};
    end

    assign evt_pulse = pick_edge(edge_sel, sh_q[SYNC_STAGES-1], sh_q[SYNC_STAGES]);

    // A detected edge of one polarity cannot repeat on the next cycle
    p_single_edge_r3: assert property (@(posedge clk) disable iff (rst)
        evt_pulse && $stable(edge_sel) |=> !evt_pulse);
endmodule

// File: rtl/tmr_count_core.sv
`timescale 1ns/1ps
module tmr_count_core #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             step_src,
    input  logic             inhibit,
    input  logic             preload_we,
    input  logic [CNT_W-1:0] preload_wdata,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

    logic [CNT_W-1:0] count_q, pre_q;
    logic             step;

    assign step  = run & step_src & ~inhibit;
    assign ovf   = step & (count_q == ALL_ONES);
    assign count = count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            pre_q   <= '0;
        end else begin
            if (preload_we) begin
                pre_q <= preload_wdata;
                if (!run) count_q <= preload_wdata;
            end else if (step) begin
                count_q <= ovf ? pre_q : count_q + 1'b1;
            end
        end
    end

    p_stopped_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!run && !preload_we) |=> $stable(count_q));
    p_inhibit_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (run && inhibit) |=> $stable(count_q));
    p_reload_r4: assert property (@(posedge clk) disable iff (rst)
        ovf |=> (count_q == $past(pre_q)));
    p_stopped_load_r8: assert property (@(posedge clk) disable iff (rst)
        (preload_we && !run) |=> (count_q == $past(preload_wdata)));
endmodule

// File: rtl/tmr_flag_unit.sv
`timescale 1ns/1ps
module tmr_flag_unit (
    input  logic clk,
    input  logic rst,
    input  logic ovf,
    input  logic ie,
    input  logic flag_we,
    input  logic flag_wdata,
    output logic flag,
    output logic irq,
    output logic wake
);
    logic flag_q, wake_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            wake_q <= 1'b0;
        end else begin
            wake_q <= ovf & ~flag_q;
            if (ovf)          flag_q <= 1'b1;
            else if (flag_we) flag_q <= flag_wdata;
        end
    end

    assign flag = flag_q;
    assign wake = wake_q;
    assign irq  = flag_q & ie;

    p_flag_on_ovf_r9: assert property (@(posedge clk) disable iff (rst)
        ovf |=> flag_q);
    p_wake_cause_r6: assert property (@(posedge clk) disable iff (rst)
        wake_q |-> ($past(ovf) && !$past(flag_q)));
    p_wake_single_r6: assert property (@(posedge clk) disable iff (rst)
        wake_q |=> !wake_q);
endmodule

// File: rtl/tmr_event_counter.sv
`timescale 1ns/1ps
module tmr_event_counter
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_we,
    input  logic [7:0]       ctrl_wdata,
    input  logic             preload_we,
    input  logic [CNT_W-1:0] preload_wdata,
    input  logic             cnt_re,
    output logic [CNT_W-1:0] cnt_rdata,
    input  logic             flag_we,
    input  logic             flag_wdata,
    input  logic             evt_in,
    output logic             irq,
    output logic             irq_flag,
    output logic             wake
);
    tmr_ctrl_t ctrl_q;
    logic      evt_pulse, step_src, ovf;
    logic      unused_ctrl_bits;

    assign unused_ctrl_bits = ^{ctrl_wdata[7:5], ctrl_wdata[3]};

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= make_ctrl(1'b0, 1'b0, 1'b0, 1'b0);
        else if (ctrl_we)
            ctrl_q <= make_ctrl(ctrl_wdata[RUN_BIT], ctrl_wdata[SRC_BIT],
                                ctrl_wdata[EDGE_BIT], ctrl_wdata[IE_BIT]);
    end

    tmr_evt_detect #(.SYNC_STAGES(SYNC_STAGES)) i_detect (
        .clk(clk), .rst(rst), .evt_in(evt_in),
        .edge_sel(ctrl_q.edge_sel), .evt_pulse(evt_pulse)
    );

    assign step_src = (ctrl_q.src == SRC_CLK) ? 1'b1 : evt_pulse;

    tmr_count_core #(.CNT_W(CNT_W)) i_core (
        .clk(clk), .rst(rst), .run(ctrl_q.run), .step_src(step_src),
        .inhibit(cnt_re | preload_we), .preload_we(preload_we),
        .preload_wdata(preload_wdata), .count(cnt_rdata), .ovf(ovf)
    );

    tmr_flag_unit i_flag (
        .clk(clk), .rst(rst), .ovf(ovf), .ie(ctrl_q.ie),
        .flag_we(flag_we), .flag_wdata(flag_wdata),
        .flag(irq_flag), .irq(irq), .wake(wake)
    );

    p_event_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.src == SRC_EVT && !evt_pulse && !preload_we) |=> $stable(cnt_rdata));
endmodule

// File: tb/test_tmr_event_counter.sv
`timescale 1ns/1ps
module test_tmr_event_counter;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ctrl_we = 1'b0;
    logic [7:0]   ctrl_wdata = '0;
    logic         preload_we = 1'b0;
    logic [W-1:0] preload_wdata = '0;
    logic         cnt_re = 1'b0;
    logic [W-1:0] cnt_rdata;
    logic         flag_we = 1'b0;
    logic         flag_wdata = 1'b0;
    logic         evt_in = 1'b0;
    logic         irq, irq_flag, wake;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    tmr_event_counter #(.CNT_W(W)) i_tmr_event_counter (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .preload_we(preload_we), .preload_wdata(preload_wdata),
        .cnt_re(cnt_re), .cnt_rdata(cnt_rdata),
        .flag_we(flag_we), .flag_wdata(flag_wdata), .evt_in(evt_in),
        .irq(irq), .irq_flag(irq_flag), .wake(wake)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr_ctrl(input logic [7:0] v);
        ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk); ctrl_we = 1'b0;
    endtask
    task automatic wr_pre(input logic [W-1:0] v);
        preload_we = 1'b1; preload_wdata = v;
        @(negedge clk); preload_we = 1'b0;
    endtask
    task automatic wr_flag(input logic v);
        flag_we = 1'b1; flag_wdata = v;
        @(negedge clk); flag_we = 1'b0;
    endtask
    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic evt_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            evt_in = 1'b1; wait_n(4);
            evt_in = 1'b0; wait_n(4);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 count", cnt_rdata, 0);
        chk("R1 flag", irq_flag, 0);
        chk("R1 irq", irq, 0);
        chk("R1 wake", wake, 0);
        wait_n(3);
        chk("R1 stopped", cnt_rdata, 0);

        // R2 R4 R5 R6 R8: sweep over every preload value in timer mode
        for (int p = 0; p < 256; p++) begin
            wr_ctrl(8'h00);
            wr_pre(W'(p));
            wr_flag(1'b0);
            chk("R8 stopped preload loads count", cnt_rdata, p);
            wr_ctrl(8'h10);
            wait_n(255 - p);
            chk("R2 count reaches all-ones", cnt_rdata, 255);
            chk("R5 flag clear before overflow", irq_flag, 0);
            wait_n(1);
            chk("R4 reload from preload", cnt_rdata, p);
            chk("R5 flag set on overflow", irq_flag, 1);
            chk("R6 wake with interrupt disabled", wake, 1);
            chk("R5 irq masked when disabled", irq, 0);
            wait_n(1);
            chk("R6 wake single cycle", wake, 0);
        end

        // R2 stop holds
        wr_ctrl(8'h00);
        wr_pre(8'h20);
        wait_n(5);
        chk("R2 stopped holds", cnt_rdata, 32);

        // R7 inhibit on read and preload write; R8 deferred preload
        wr_pre(8'h00);
        wr_flag(1'b0);
        wr_ctrl(8'h10);
        wait_n(10);
        chk("R2 ten steps", cnt_rdata, 10);
        cnt_re = 1'b1; @(negedge clk); cnt_re = 1'b0;
        chk("R7 read drops step", cnt_rdata, 10);
        wr_pre(8'hF0);
        chk("R7 preload write drops step", cnt_rdata, 10);
        chk("R8 running preload leaves count", cnt_rdata, 10);
        wait_n(245);
        chk("R7 counting resumed", cnt_rdata, 255);
        wait_n(1);
        chk("R8 new preload used at overflow", cnt_rdata, 240);

        // R5 irq with enable; R6 no wake when flag already set
        wr_ctrl(8'h00);
        wr_pre(8'hFE);
        wr_flag(1'b0);
        wr_ctrl(8'h14);
        wait_n(2);
        chk("R5 irq asserted", irq, 1);
        chk("R6 wake with interrupt enabled", wake, 1);
        wr_ctrl(8'h10);
        chk("R5 irq drops with enable off", irq, 0);
        chk("R5 flag kept", irq_flag, 1);
        wr_ctrl(8'h00);
        wr_pre(8'hFE);
        wr_ctrl(8'h10);            // flag still set
        wait_n(2);
        chk("R6 no wake with flag preset", wake, 0);
        chk("R6 flag remains", irq_flag, 1);

        // R9 clear colliding with overflow
        wr_ctrl(8'h00);
        wr_pre(8'hFE);
        wr_ctrl(8'h10);
        wait_n(1);                  // count now FF
        chk("R9 setup all-ones", cnt_rdata, 255);
        wr_flag(1'b0);              // overflow edge in this write
        chk("R9 clear loses to overflow", irq_flag, 1);
        chk("R9 collision count reloaded", cnt_rdata, 254);
        wr_ctrl(8'h00);
        wr_flag(1'b0);
        chk("R9 host clear", irq_flag, 0);
        wr_flag(1'b1);
        chk("R9 host set", irq_flag, 1);
        chk("R9 host set irq masked", irq, 0);
        wr_flag(1'b0);

        // R3 event mode, rising edges
        wr_pre(8'h00);
        wr_ctrl(8'h11);
        wait_n(6);
        chk("R3 no events no count", cnt_rdata, 0);
        evt_in = 1'b1;
        wait_n(2);
        chk("R3 not yet counted after two edges", cnt_rdata, 0);
        wait_n(1);
        chk("R3 counted on third edge", cnt_rdata, 1);
        wait_n(1);
        evt_in = 1'b0; wait_n(4);
        chk("R3 falling ignored in rising mode", cnt_rdata, 1);
        evt_pulses(5);
        chk("R3 rising pulses", cnt_rdata, 6);

        // R3 event mode, falling edges
        wr_ctrl(8'h03);
        wr_pre(8'h00);
        wr_ctrl(8'h13);
        evt_pulses(7);
        chk("R3 falling pulses", cnt_rdata, 7);
        evt_in = 1'b1; wait_n(6);
        chk("R3 rising ignored in falling mode", cnt_rdata, 7);
        evt_in = 1'b0; wait_n(4);
        chk("R3 final fall", cnt_rdata, 8);

        // R6 wake in event mode
        wr_ctrl(8'h03);
        wr_pre(8'hFF);
        wr_flag(1'b0);
        wr_ctrl(8'h13);
        evt_in = 1'b1; wait_n(4);
        evt_in = 1'b0; wait_n(3);
        chk("R6 event overflow wake", wake, 1);
        chk("R4 event overflow reload", cnt_rdata, 255);
        wait_n(1);
        chk("R6 event wake ends", wake, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule